// File: doc/BRIEF.md
# Channel-Zero Message Extractor

This block watches time slot 0 on a group of serial PCM input lines and passes the slot-0 bytes that carry real messages to a control processor. The processor writes a line mask that selects which lines are watched. The mask is held in two places: a background copy and a working copy. At every frame boundary the engine reloads the working copy from the background copy, keeps only the selected lines whose slot-0 byte is a message, and captures the slot-0 bytes of all lines.

If at least one message is found, the engine pulls its interrupt line low for two cycles and puts the message count in its status register. The processor then reads the messages out one per status read, from the highest line number to the lowest. Each step shows the message byte and the line it came from, with a flag that tells whether more messages remain. A new frame boundary drops any readout that is not finished and starts over from the background copy. The slot-0 data is given as one byte per line, sampled on the frame-start cycle.

Top module: `chz_extract`

## Requirements
- R1: A mask write with a non-zero value loads both the background and the working mask and disarms any pending readout. The status output then reads {count of ones in the mask, flag=1, kind=3'b001}. Status layout: bits [7:4] value, bit [3] flag, bits [2:0] kind.
- R2: A mask write of zero clears both masks, sets status to {0, flag=0, 3'b001} and disables extraction. Reset gives msg_q=0, stat_q=0 and irq_n=1.
- R3: A slot-0 byte is a message only when its two most significant bits are not 2'b01.
- R4: On a frame-start cycle, the working mask becomes background mask AND message-present. If this is non-zero, status becomes {number of such lines, flag=1, kind=3'b010} in the next cycle.
- R5: After a frame start that finds messages, irq_n is low for exactly the two cycles that follow the frame-start edge. A frame start that finds no messages leaves irq_n high.
- R6: Each stat_rd pulse during an armed readout loads msg_q with the captured byte of the next line and sets status to {line number, flag Fn, kind=3'b100}. Fn=1 means more messages remain and Fn=0 means this is the last one.
- R7: Readout steps go from the highest selected line to the lowest.
- R8: A stat_rd pulse after the last step, or when no readout is armed, changes neither msg_q nor stat_q.
- R9: A frame start during an unfinished readout discards it and begins a new evaluation from the background mask.
- R10: When mask_we and frame_start occur in the same cycle, the mask write takes effect and the frame start is ignored: no interrupt and no announcement.
- R11: The slot-0 bytes are captured on the frame-start cycle. Later changes on slot0_bus do not change the bytes delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| slot0_bus | input | LINES*BYTE_W | Slot-0 byte of each line; line i at bits [i*8+7 : i*8] |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | LINES | Line mask; bit i selects line i |
| stat_rd | input | 1 | Status read pulse; advances an armed readout |
| msg_q | output | BYTE_W | Message byte of the current step |
| stat_q | output | 8 | Status: value, flag and kind |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
The mask store and the frame-boundary evaluation can fall in the same cycle, and so can a frame boundary and a readout step. The bench drives mask_we together with frame_start while messages are waiting, and checks that the status shows the mask result and that no interrupt appears. It also raises frame_start in the middle of a readout and checks that the step sequence restarts from the full set of lines. A behavioural queue model predicts msg_q, stat_q and irq_n for every cycle, and the outputs are compared with it on each clock.

// File: rtl/chz_pkg.sv
package chz_pkg;
  localparam int KIND_W = 3;
  typedef enum logic [KIND_W-1:0] {
    K_NONE = 3'b000,
    K_MASK = 3'b001,
    K_ANN  = 3'b010,
    K_STEP = 3'b100
  } kind_e;
endpackage

// File: rtl/chz_label_qual.sv
module chz_label_qual #(
  parameter int LINES = 8,
  parameter logic [1:0] SKIP_LABEL = 2'b01
) (
  input  logic [2*LINES-1:0] labels_i,
  output logic [LINES-1:0]   present_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign present_o[g] = (labels_i[2*g +: 2] != SKIP_LABEL);
  end
endmodule

// File: rtl/chz_pick_high.sv
module chz_pick_high #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/chz_extract.sv
module chz_extract
  import chz_pkg::*;
#(
  parameter int LINES = 8,
  parameter int BYTE_W = 8,
  parameter int IRQ_CYC = 2,
  parameter logic [1:0] SKIP_LABEL = 2'b01,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CNT_W = $clog2(LINES + 1),
  localparam int STAT_W = CNT_W + 1 + KIND_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic [LINES*BYTE_W-1:0] slot0_bus,
  input  logic                    mask_we,
  input  logic [LINES-1:0]        mask_wdata,
  input  logic                    stat_rd,
  output logic [BYTE_W-1:0]       msg_q,
  output logic [STAT_W-1:0]       stat_q,
  output logic                    irq_n
);
  localparam int IRQ_W = $clog2(IRQ_CYC + 1);

  logic [LINES-1:0]   bg_q, work_q;
  logic               armed_q;
  logic [IRQ_W-1:0]   irq_cnt_q;
  logic [BYTE_W-1:0]  cap_q [LINES];

  logic [2*LINES-1:0] labels;
  logic [LINES-1:0]   present, qual, work_after;
  logic [LINE_W-1:0]  pick_idx;
  logic               pick_any, more;
  logic               fs_eff, fs_hit, step;

  function automatic logic [CNT_W-1:0] ones(input logic [LINES-1:0] v);
    ones = '0;
    for (int i = 0; i < LINES; i++) ones = ones + CNT_W'(v[i]);
  endfunction

  for (genvar g = 0; g < LINES; g++) begin : g_lab
    assign labels[2*g +: 2] = slot0_bus[g*BYTE_W + BYTE_W - 2 +: 2];
  end

  chz_label_qual #(.LINES(LINES), .SKIP_LABEL(SKIP_LABEL)) u_qual (
    .labels_i (labels),
    .present_o(present)
  );

  chz_pick_high #(.N(LINES)) u_pick (
    .req_i(work_q),
    .idx_o(pick_idx),
    .any_o(pick_any)
  );

  always_comb begin
    qual       = bg_q & present;
    work_after = work_q;
    work_after[pick_idx] = 1'b0;
    more       = |work_after;
    fs_eff     = frame_start && !mask_we;
    fs_hit     = fs_eff && (|qual);
    step       = !mask_we && !frame_start && stat_rd && armed_q && pick_any;
  end

  // mask, readout and status registers
  always_ff @(posedge clk) begin
    if (rst) begin
      bg_q    <= '0;
      work_q  <= '0;
      armed_q <= 1'b0;
      msg_q   <= '0;
      stat_q  <= '0;
    end else if (mask_we) begin
      bg_q    <= mask_wdata;
      work_q  <= mask_wdata;
      armed_q <= 1'b0;
      stat_q  <= {ones(mask_wdata), |mask_wdata, K_MASK};
    end else if (fs_eff) begin
      work_q  <= qual;
      armed_q <= |qual;
      if (|qual) stat_q <= {ones(qual), 1'b1, K_ANN};
    end else if (step) begin
      msg_q   <= cap_q[pick_idx];
      stat_q  <= {CNT_W'(pick_idx), more, K_STEP};
      work_q  <= work_after;
      armed_q <= more;
    end
  end

  // slot-0 capture, one byte per line
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (rst) cap_q[i] <= '0;
      else if (fs_eff) cap_q[i] <= slot0_bus[i*BYTE_W +: BYTE_W];
    end
  end

  // interrupt pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cnt_q <= '0;
      irq_n     <= 1'b1;
    end else if (fs_hit) begin
      irq_cnt_q <= IRQ_W'(IRQ_CYC - 1);
      irq_n     <= 1'b0;
    end else if (irq_cnt_q != '0) begin
      irq_cnt_q <= irq_cnt_q - 1'b1;
      irq_n     <= 1'b0;
    end else begin
      irq_n     <= 1'b1;
    end
  end
endmodule

// File: rtl/chz_extract_chk.sv
module chz_extract_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mask_we,
  input logic [LINES-1:0] mask_wdata,
  input logic             frame_start,
  input logic             stat_rd,
  input logic             irq_n,
  input logic [LINES-1:0] bg_q,
  input logic [LINES-1:0] work_q,
  input logic             armed_q
);
  assert_mask_load_R1: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (bg_q == $past(mask_wdata) && !armed_q));

  assert_null_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_we && mask_wdata == '0) |=> (bg_q == '0 && work_q == '0));

  assert_work_subset_R4: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ((work_q & ~bg_q) == '0));

  assert_irq_armed_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> armed_q);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |=> !irq_n);

  assert_irq_end_R5: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && $past(!irq_n) && !$past(frame_start) && !frame_start) |=> irq_n);

  assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && armed_q && !mask_we && !frame_start)
      |=> ($countones(work_q) == $countones($past(work_q)) - 1));

  assert_mix_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_we && frame_start) |=> irq_n);
endmodule

bind chz_extract chz_extract_chk #(.LINES(LINES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mask_we    (mask_we),
  .mask_wdata (mask_wdata),
  .frame_start(frame_start),
  .stat_rd    (stat_rd),
  .irq_n      (irq_n),
  .bg_q       (bg_q),
  .work_q     (work_q),
  .armed_q    (armed_q)
);

// File: tb/sim_chz_extract.sv
module sim_chz_extract;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [63:0] slot0_bus;
  logic [7:0]  msg_q;
  logic [7:0]  stat_q;
  logic        irq_n;
  logic [7:0]  bytes_in [8];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R2";

  // reference model state
  logic [7:0] m_bg;
  bit         m_armed;
  int         m_pend[$];
  logic [7:0] m_cap [8];
  int         m_irq_left;
  logic [7:0] e_msg, e_stat;
  logic       e_irqn;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) slot0_bus[i*8 +: 8] = bytes_in[i];

  chz_extract u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .slot0_bus(slot0_bus),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .stat_rd(stat_rd),
    .msg_q(msg_q), .stat_q(stat_q), .irq_n(irq_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired: actual=%0d expected<=20000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_reset();
    m_bg = '0; m_armed = 0; m_pend.delete(); m_irq_left = 0;
    for (int i = 0; i < 8; i++) m_cap[i] = '0;
    e_msg = '0; e_stat = '0; e_irqn = 1'b1;
  endtask

  // advance the model by one clock edge using the current inputs
  task automatic model_step();
    bit hit = 0;
    if (mask_we) begin
      m_bg = mask_wdata; m_armed = 0; m_pend.delete();
      e_stat = {4'(popc(mask_wdata)), |mask_wdata, 3'b001};
    end else if (frame_start) begin
      m_pend.delete();
      for (int i = 0; i < 8; i++) m_cap[i] = bytes_in[i];
      for (int i = 7; i >= 0; i--)
        if (m_bg[i] && bytes_in[i][7:6] != 2'b01) m_pend.push_back(i);
      m_armed = (m_pend.size() > 0);
      if (m_armed) begin
        e_stat = {4'(m_pend.size()), 1'b1, 3'b010};
        hit = 1;
      end
    end else if (stat_rd && m_armed) begin
      int l = m_pend.pop_front();
      bit more = (m_pend.size() > 0);
      e_msg = m_cap[l];
      e_stat = {4'(l), more, 3'b100};
      m_armed = more;
    end
    if (hit) m_irq_left = 2;
    e_irqn = (m_irq_left > 0) ? 1'b0 : 1'b1;
    if (m_irq_left > 0) m_irq_left--;
  endtask

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    chk("msg_q", msg_q, e_msg);
    chk("stat_q", stat_q, e_stat);
    chk("irq_n", {7'd0, irq_n}, {7'd0, e_irqn});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    frame_start = 0; mask_we = 0; stat_rd = 0;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_mask(logic [7:0] v);
    mask_we = 1; mask_wdata = v; tick();
  endtask

  task automatic do_frame();
    frame_start = 1; tick();
  endtask

  task automatic do_read();
    stat_rd = 1; tick();
  endtask

  task automatic set_bytes(int seed, logic [7:0] skip);
    for (int i = 0; i < 8; i++)
      bytes_in[i] = {(skip[i] ? 2'b01 : 2'(i + seed)), 6'(i * 7 + seed)};
    // keep non-skipped labels away from 01
    for (int i = 0; i < 8; i++)
      if (!skip[i] && bytes_in[i][7:6] == 2'b01) bytes_in[i][7:6] = 2'b11;
  endtask

  initial begin
    set_bytes(0, 8'h00);
    model_reset();
    @(negedge clk); @(negedge clk);
    cur_req = "R2"; compare();             // reset state
    rst = 0;
    idle(1);
    cur_req = "R8"; do_read(); idle(1);     // read with nothing armed

    cur_req = "R1"; do_mask(8'hA5); idle(2);
    cur_req = "R8"; do_read();              // armed is off after mask store

    // lines 7,5,2,0 selected; line 5 labelled 01
    cur_req = "R3"; set_bytes(3, 8'h20);
    cur_req = "R4"; do_frame();
    cur_req = "R5"; idle(3);
    cur_req = "R11"; set_bytes(9, 8'h00);   // bus changes after capture
    cur_req = "R7";
    for (int i = 0; i < 3; i++) begin do_read(); idle(1); end
    cur_req = "R8"; do_read(); do_read(); idle(1);

    // frame boundary in mid readout
    cur_req = "R6"; do_mask(8'hFF); set_bytes(5, 8'h00);
    do_frame(); idle(2); do_read(); do_read();
    cur_req = "R9"; set_bytes(6, 8'h81); do_frame(); idle(2);
    for (int i = 0; i < 7; i++) do_read();
    cur_req = "R8"; do_read();

    // mask write and frame start in the same cycle
    cur_req = "R10"; set_bytes(2, 8'h00);
    mask_we = 1; mask_wdata = 8'h3C; frame_start = 1; tick(); idle(3);
    cur_req = "R8"; do_read();
    cur_req = "R4"; do_frame(); idle(2);
    cur_req = "R6"; for (int i = 0; i < 4; i++) do_read();

    // null mask disables extraction
    cur_req = "R2"; do_mask(8'h00); idle(1);
    do_frame(); idle(3); do_read();

    // every line a message except one: labels on lines 0 and 7
    cur_req = "R3"; do_mask(8'h81); set_bytes(1, 8'h01);
    do_frame(); idle(2);
    cur_req = "R7"; do_read(); do_read(); idle(1);
    cur_req = "R5"; set_bytes(1, 8'h81); do_frame(); idle(3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule